// File: doc/BRIEF.md
# Shared-Bus Configuration Latch Bank

This block holds three small configuration words that are all written through one shared 8-bit enable bus. Each word has its own active-high load strobe. While a strobe is high its word is transparent: the output follows the bus. When the strobe drops, the word keeps the last bus value it saw. One word drives the serial output-driver enables. One drives the transmit/receive self-test selects, where a 0 selects pattern generation or comparison. The third drives four receive-channel power enables.

The bus and the three strobes come from asynchronous pins. They pass through a shared two-stage synchroniser (depth set by `SYNC_STAGES`) before they reach the latches. The bus and the strobes are synchronised in the same flops, so a strobe and the data beside it stay aligned. The reset input `rst_ni` is sampled on the rising clock edge. While a word's strobe is low, a sampled low reset loads that word's safe default. A word whose strobe is high ignores reset.

Top module: `cfg_latch_bank`

## Requirements
- R1: While a strobe is high, the matching word's output equals the synchronised bus value, and it tracks every later bus change.
- R2: When a strobe falls, the word keeps the bus value that was synchronised in the last cycle the strobe was high. The output does not change in the cycle of the fall.
- R3: While a strobe is low and reset is high, bus changes do not alter that word's output.
- R4: In `drv_en_o`, bit i = 1 enables serial driver i and 0 powers it down. A sampled low reset with the strobe low loads 8'hFF, which enables all drivers.
- R5: In `st_norm_o`, bit i = 0 selects pattern generate/compare on channel i and 1 selects normal operation. A sampled low reset with the strobe low loads 8'hFF, which turns self-test off everywhere.
- R6: `rx_pwr_o[k]` is taken from bus bit `RX_OFS+k`, which is bits 7:4 by default. A 1 keeps receive channel k powered. Bus bits outside that field do not affect `rx_pwr_o`. A sampled low reset with the strobe low loads 4'hF.
- R7: Reset does not affect a word whose strobe is high: its output keeps following the bus.
- R8: A strobe loads only its own word. The other two words keep their values.
- R9: A bus change reaches the output of an open word on the second rising edge after the change, and not on the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset, sampled on the rising edge |
| bus_i | input | 8 | Shared asynchronous enable bus |
| drv_le_i | input | 1 | Strobe for the driver-enable word (asynchronous) |
| st_le_i | input | 1 | Strobe for the self-test word (asynchronous) |
| rx_le_i | input | 1 | Strobe for the receive-power word (asynchronous) |
| drv_en_o | output | 8 | Serial driver enables, 1 = on |
| st_norm_o | output | 8 | Self-test selects, 0 = pattern mode |
| rx_pwr_o | output | 4 | Receive channel power enables, 1 = on |

## Verification
A bus or strobe change made between edges reaches an open word's output after two rising edges, because the synchroniser has two stages and the transparent path is combinational. The captured value and the reset default are settled in the holding register one edge later. For that reason the driver waits three rising edges after each stimulus before it queues the expected words. For the latency case it queues one item after the first edge, which must still show the old value, and one after the second edge. The monitor samples each item at the falling edge that follows, clear of the edge where the registers update.

// File: rtl/cfg_latch_pkg.sv
package cfg_latch_pkg;
  localparam int unsigned BUS_W  = 8;
  localparam int unsigned RX_CH  = 4;
  localparam int unsigned RX_OFS = 4;

  // strobe positions in the synchronised vector, above the bus bits
  typedef enum int unsigned {
    LE_DRV = 0,
    LE_ST  = 1,
    LE_RX  = 2,
    LE_NUM = 3
  } le_idx_e;
endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk_i) begin
    stg_q[0] <= d_i;
    for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/cfg_latch_slot.sv
module cfg_latch_slot #(
  parameter int unsigned   W       = 8,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         le_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] held_q;

  // open strobe wins over reset
  always_ff @(posedge clk_i) begin
    if (le_i)         held_q <= d_i;
    else if (!rst_ni) held_q <= RST_VAL;
  end

  assign q_o = le_i ? d_i : held_q;

  AST_FALL_NO_GLITCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(le_i) |-> $stable(q_o)); // R2

  AST_CAPTURE_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(le_i) |-> q_o == $past(d_i)); // R2

  AST_HOLD_CLOSED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!le_i && $past(!le_i) && $past(rst_ni)) |-> $stable(q_o)); // R3

  AST_RST_DEFAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(rst_ni) && !le_i && $past(!le_i)) |-> q_o == RST_VAL); // R4
endmodule

// File: rtl/cfg_latch_bank.sv
module cfg_latch_bank
  import cfg_latch_pkg::*;
#(
  parameter int unsigned BUS_WIDTH   = BUS_W,
  parameter int unsigned RX_CHANNELS = RX_CH,
  parameter int unsigned RX_BASE     = RX_OFS,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [BUS_WIDTH-1:0]   bus_i,
  input  logic                   drv_le_i,
  input  logic                   st_le_i,
  input  logic                   rx_le_i,
  output logic [BUS_WIDTH-1:0]   drv_en_o,
  output logic [BUS_WIDTH-1:0]   st_norm_o,
  output logic [RX_CHANNELS-1:0] rx_pwr_o
);
  localparam int unsigned LE_CNT = int'(LE_NUM);
  localparam int unsigned SYNC_W = BUS_WIDTH + LE_CNT;

  logic [SYNC_W-1:0]    raw_in, sync_out;
  logic [BUS_WIDTH-1:0] bus_s;
  logic [LE_CNT-1:0]    le_s;

  assign raw_in = {rx_le_i, st_le_i, drv_le_i, bus_i};

  cfg_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .d_i   (raw_in),
    .q_o   (sync_out)
  );

  assign bus_s = sync_out[BUS_WIDTH-1:0];
  assign le_s  = sync_out[SYNC_W-1:BUS_WIDTH];

  cfg_latch_slot #(.W(BUS_WIDTH), .RST_VAL({BUS_WIDTH{1'b1}})) u_drv (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .le_i   (le_s[LE_DRV]),
    .d_i    (bus_s),
    .q_o    (drv_en_o)
  );

  cfg_latch_slot #(.W(BUS_WIDTH), .RST_VAL({BUS_WIDTH{1'b1}})) u_st (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .le_i   (le_s[LE_ST]),
    .d_i    (bus_s),
    .q_o    (st_norm_o)
  );

  cfg_latch_slot #(.W(RX_CHANNELS), .RST_VAL({RX_CHANNELS{1'b1}})) u_rx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .le_i   (le_s[LE_RX]),
    .d_i    (bus_s[RX_BASE +: RX_CHANNELS]),
    .q_o    (rx_pwr_o)
  );

  initial begin
    AST_RX_FIELD_FITS: assert (RX_BASE + RX_CHANNELS <= BUS_WIDTH); // R6
  end
endmodule

// File: tb/cfg_latch_bank_bench.sv
module cfg_latch_bank_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] bus;
  logic       drv_le, st_le, rx_le;
  logic [7:0] drv_en, st_norm;
  logic [3:0] rx_pwr;

  always #4 clk = ~clk; // 125 MHz

  cfg_latch_bank u_cfg_latch_bank (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .bus_i     (bus),
    .drv_le_i  (drv_le),
    .st_le_i   (st_le),
    .rx_le_i   (rx_le),
    .drv_en_o  (drv_en),
    .st_norm_o (st_norm),
    .rx_pwr_o  (rx_pwr)
  );

  typedef struct {
    logic [7:0] drv;
    logic [7:0] st;
    logic [3:0] rx;
    string      req;
  } exp_t;

  exp_t sb_q[$];
  int total = 0;
  int bad   = 0;
  logic [7:0] m_drv = 8'hFF, m_st = 8'hFF;
  logic [3:0] m_rx = 4'hF;

  task automatic chk(string req, string what, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  task automatic push(string req);
    exp_t e;
    e.drv = m_drv; e.st = m_st; e.rx = m_rx; e.req = req;
    sb_q.push_back(e);
  endtask

  // model built from the requirements, settled three edges after the drive
  task automatic step(logic [7:0] b, logic d, logic s, logic r, logic rs, string req);
    @(negedge clk);
    bus = b; drv_le = d; st_le = s; rx_le = r; rst_n = rs;
    repeat (3) @(posedge clk);
    if (d) m_drv = b; else if (!rs) m_drv = 8'hFF;
    if (s) m_st  = b; else if (!rs) m_st  = 8'hFF;
    if (r) m_rx  = b[7:4]; else if (!rs) m_rx = 4'hF;
    push(req);
  endtask

  // R9: old value after the first edge, new value after the second
  task automatic latency(logic [7:0] b);
    @(negedge clk);
    bus = b;
    @(posedge clk);
    push("R9 first edge");
    @(posedge clk);
    m_drv = b;
    push("R9 second edge");
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(negedge clk);
      if (sb_q.size() > 0) begin
        e = sb_q.pop_front();
        chk(e.req, "drv_en", drv_en, e.drv);
        chk(e.req, "st_norm", st_norm, e.st);
        chk(e.req, "rx_pwr", {4'h0, rx_pwr}, {4'h0, e.rx});
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : driver
    bus = 8'h00; drv_le = 1'b0; st_le = 1'b0; rx_le = 1'b0; rst_n = 1'b0;
    step(8'h00, 0, 0, 0, 0, "R4 R5 R6 reset defaults");
    step(8'h00, 0, 0, 0, 1, "R3 closed after reset");
    step(8'hA5, 1, 0, 0, 1, "R1 R4 R8 open driver word");
    step(8'h3C, 1, 0, 0, 1, "R1 follow bus change");
    step(8'h3C, 0, 0, 0, 1, "R2 capture on fall");
    step(8'h99, 0, 0, 0, 1, "R3 closed ignores bus");
    step(8'h5A, 0, 1, 0, 1, "R5 R8 open self-test word");
    step(8'hF0, 0, 0, 0, 1, "R2 self-test fall with bus change");
    step(8'hC3, 0, 0, 1, 1, "R6 R8 open rx word");
    step(8'hC5, 0, 0, 1, 1, "R6 unused bits ignored");
    step(8'h3A, 0, 0, 1, 1, "R6 field follows");
    step(8'h00, 0, 0, 0, 1, "R2 rx capture");
    step(8'h00, 1, 0, 0, 1, "R1 prep latency");
    latency(8'hE7);
    step(8'h77, 1, 0, 0, 1, "R1 open before reset");
    step(8'h77, 1, 0, 0, 0, "R7 R5 R6 reset with driver open");
    step(8'h11, 1, 0, 0, 0, "R7 open word follows during reset");
    step(8'h11, 0, 0, 0, 1, "R2 close after reset");
    step(8'h81, 1, 1, 1, 1, "R1 all open");
    step(8'h00, 0, 0, 0, 1, "R2 all close with bus change");
    step(8'h42, 0, 0, 0, 1, "R3 all closed ignore bus");
    step(8'h42, 0, 0, 0, 0, "R4 R5 R6 reset all closed");
    step(8'h42, 0, 0, 0, 1, "R3 after reset release");
    while (sb_q.size() > 0) @(negedge clk);
    @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule